// File: doc/BRIEF.md
# Halt and Wake-up Sequencer

This block runs the power-down mode of a small processor core. When the core issues a one-cycle halt strobe, the sequencer drops the core clock enable. RAM and registers hold their contents because the core simply stops advancing. The sequencer also pulses a clear to the watchdog prescaler, sets the power-down status flag and clears the timeout status flag.

While halted it watches two wake sources. The first is a falling edge on any bit of an 8-bit input port whose per-bit enable is set. The second is a wake request from the watchdog. An external reset, the asynchronous active-low reset, is a third way out: it reinitializes everything at once. Port inputs pass through a two-flop synchronizer before edge detection, which compares the previous synchronized sample with the current one.

After a wake, the core stays stalled for a fixed settling period of `DELAY_CYC` system clocks, 1024 by default. The sequencer then re-enables the core and issues a one-cycle resume pulse. Alongside that pulse, `restart_pc` tells the core how to resume:
- 0 means continue at the instruction after the halt (port wake).
- 1 means restart the program counter (watchdog wake).

All pins are plain control and status signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `halt_wake_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `core_en`=1, `pdf_flag`=0, `to_flag`=0, `wdt_pre_clr`=0, `resume_pulse`=0 and `restart_pc`=0.
- R2: A `halt_req` sampled high at a clock edge while `core_en`=1 makes, right after that edge, `core_en`=0, `pdf_flag`=1, `to_flag`=0, and `wdt_pre_clr`=1 for exactly one cycle.
- R3: While halted, a high-to-low change on `port_in[i]` with `wake_mask[i]`=1 wakes the block. The wake is seen 3 edges after the input changes: two synchronizer stages, then the edge compare. Changes on bits with `wake_mask[i]`=0, and rising edges, do not wake it.
- R4: After the edge that detects a wake, `core_en` stays 0 for `DELAY_CYC` further edges. Then `resume_pulse` is high for exactly one cycle, with `core_en`=1 at the same time. A port-driven change reaches `resume_pulse` `DELAY_CYC`+3 edges after the input changes; a watchdog request reaches it `DELAY_CYC`+1 edges after it is applied.
- R5: A wake caused by `wdt_wake` sets `to_flag`=1 at the detecting edge and gives `restart_pc`=1 with the resume pulse. A port wake gives `restart_pc`=0. If both are present at the same edge, the watchdog cause wins.
- R6: `wdt_clr` while running clears `pdf_flag` at the next edge. If `halt_req` arrives at the same edge, the halt wins and `pdf_flag` becomes 1.
- R7: `halt_req` while halted or settling is ignored: the resume still comes at the R4 cycle.
- R8: Pulling `rst_n` low during halt or settling returns the outputs to the R1 values immediately, and no resume pulse follows.
- R9: While running, port falling edges and `wdt_wake` have no effect; `core_en` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External/power-up reset, asynchronous, active low |
| halt_req | input | 1 | One-cycle halt strobe from the core |
| wdt_clr | input | 1 | Watchdog clear command from the core (clears the power-down flag) |
| wdt_wake | input | 1 | Watchdog wake request |
| port_in | input | PORT_W | Asynchronous input port watched for falling edges |
| wake_mask | input | PORT_W | Per-bit wake enable for `port_in` |
| core_en | output | 1 | Core clock enable |
| wdt_pre_clr | output | 1 | One-cycle clear to the watchdog prescaler on halt entry |
| pdf_flag | output | 1 | Power-down status flag |
| to_flag | output | 1 | Timeout status flag |
| resume_pulse | output | 1 | One-cycle pulse when the core is released |
| restart_pc | output | 1 | With `resume_pulse`: 1 = restart program counter, 0 = continue |

## Verification
The bench measures the exact resume cycle for port and watchdog wakes. A counter that is off by one, or a synchronizer with a stage missing, would shift that stamp. It also re-strobes halt in the middle of settling, which catches a design that reloads the delay or halts again.

It drops a port bit whose enable is clear and checks that the core stays stalled. It applies a port edge and a watchdog request at the same edge to expose reversed cause priority. It resets during settling: a design that kept a pending resume would raise an unexpected pulse, and the scoreboard flags it.

// File: rtl/pwr_halt_pkg.sv
package pwr_halt_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_SETTLE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/port_fall_detect.sv
module port_fall_detect #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin,
  input  logic [PORT_W-1:0] en_mask,
  output logic              fall_hit
);
  logic [PORT_W-1:0] bit_fall;

  for (genvar i = 0; i < PORT_W; i++) begin : g_bit
    logic s1_q, s2_q, prev_q;
    // idle level of a port pin is high; reset there so no false edge appears
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b1;
        s2_q   <= 1'b1;
        prev_q <= 1'b1;
      end else begin
        s1_q   <= pin[i];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign bit_fall[i] = prev_q & ~s2_q & en_mask[i];
  end

  assign fall_hit = |bit_fall;

  // R3: a reported edge needs at least one enabled bit
  a_r3_edge_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    fall_hit |-> (|en_mask));
endmodule

// File: rtl/wake_settle_timer.sv
module wake_settle_timer #(
  parameter int DELAY_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire
);
  localparam int CNT_W = (DELAY_CYC > 2) ? $clog2(DELAY_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= LAST;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign expire = busy_q && (cnt_q == '0);

  // R4: a new settle never starts while one is running
  a_r4_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  // R4: expiry ends the settle period
  a_r4_expire_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !busy_q);
  // R4: count stays inside its load range
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST));
endmodule

// File: rtl/halt_seq_fsm.sv
module halt_seq_fsm
  import pwr_halt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic halt_req,
  input  logic wdt_clr,
  input  logic wdt_wake,
  input  logic port_fall,
  input  logic settle_done,
  output logic settle_start,
  output logic core_en,
  output logic pdf_flag,
  output logic to_flag,
  output logic wdt_pre_clr,
  output logic resume_pulse,
  output logic restart_pc
);
  seq_state_t st_q;
  logic       cause_wdt_q;
  logic       wake_any;

  assign wake_any     = port_fall | wdt_wake;
  assign settle_start = (st_q == ST_HALT) && wake_any;
  assign core_en      = (st_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_RUN;
      cause_wdt_q  <= 1'b0;
      pdf_flag     <= 1'b0;
      to_flag      <= 1'b0;
      wdt_pre_clr  <= 1'b0;
      resume_pulse <= 1'b0;
      restart_pc   <= 1'b0;
    end else begin
      wdt_pre_clr  <= 1'b0;
      resume_pulse <= 1'b0;
      restart_pc   <= 1'b0;
      unique case (st_q)
        ST_RUN: begin
          if (halt_req) begin
            st_q        <= ST_HALT;
            pdf_flag    <= 1'b1;
            to_flag     <= 1'b0;
            wdt_pre_clr <= 1'b1;
          end else if (wdt_clr) begin
            pdf_flag <= 1'b0;
          end
        end
        ST_HALT: begin
          if (wake_any) begin
            st_q        <= ST_SETTLE;
            cause_wdt_q <= wdt_wake;
            if (wdt_wake) to_flag <= 1'b1;
          end
        end
        ST_SETTLE: begin
          if (settle_done) begin
            st_q         <= ST_RUN;
            resume_pulse <= 1'b1;
            restart_pc   <= cause_wdt_q;
          end
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  // R2: halt strobe while running stops the core and updates the flags
  a_r2_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && halt_req) |=> (!core_en && pdf_flag && !to_flag && wdt_pre_clr));
  // R2: prescaler clear lasts one cycle
  a_r2_pre_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_pre_clr |=> !wdt_pre_clr);
  // R4: resume coincides with the enable
  a_r4_resume_runs: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |-> core_en);
  // R4: resume is a single pulse
  a_r4_resume_once: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |=> !resume_pulse);
  // R5: restart indication only appears with resume
  a_r5_restart_with_resume: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pc |-> resume_pulse);
  // R5: watchdog wake while halted marks timeout
  a_r5_wdt_sets_to: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT && wdt_wake) |=> to_flag);
  // R6: clear while running drops the flag
  a_r6_clr_drops_pdf: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && wdt_clr && !halt_req) |=> !pdf_flag);
  // R7: settling is not left early, whatever the halt strobe does
  a_r7_settle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SETTLE && !settle_done) |=> (st_q == ST_SETTLE));
  // R9: running without a halt strobe stays running
  a_r9_run_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && !halt_req) |=> core_en);
endmodule

// File: rtl/halt_wake_seq.sv
module halt_wake_seq #(
  parameter int PORT_W    = 8,
  parameter int DELAY_CYC = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_req,
  input  logic              wdt_clr,
  input  logic              wdt_wake,
  input  logic [PORT_W-1:0] port_in,
  input  logic [PORT_W-1:0] wake_mask,
  output logic              core_en,
  output logic              wdt_pre_clr,
  output logic              pdf_flag,
  output logic              to_flag,
  output logic              resume_pulse,
  output logic              restart_pc
);
  logic port_fall;
  logic settle_start;
  logic settle_done;

  port_fall_detect #(.PORT_W(PORT_W)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (port_in),
    .en_mask  (wake_mask),
    .fall_hit (port_fall)
  );

  wake_settle_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (settle_start),
    .expire (settle_done)
  );

  halt_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt_req     (halt_req),
    .wdt_clr      (wdt_clr),
    .wdt_wake     (wdt_wake),
    .port_fall    (port_fall),
    .settle_done  (settle_done),
    .settle_start (settle_start),
    .core_en      (core_en),
    .pdf_flag     (pdf_flag),
    .to_flag      (to_flag),
    .wdt_pre_clr  (wdt_pre_clr),
    .resume_pulse (resume_pulse),
    .restart_pc   (restart_pc)
  );

  // R8: while reset is held the core is enabled
  a_r8_reset_enables: assert property (@(posedge clk)
    !rst_n |-> (core_en && !pdf_flag && !resume_pulse));
endmodule

// File: tb/halt_wake_seq_tb.sv
module halt_wake_seq_tb;
  localparam int PW    = 8;
  localparam int DLY   = 1024;
  localparam int LIMIT = 50000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          halt_req = 1'b0, wdt_clr = 1'b0, wdt_wake = 1'b0;
  logic [PW-1:0] port_in = '1;
  logic [PW-1:0] wake_mask = 8'h01;
  logic core_en, wdt_pre_clr, pdf_flag, to_flag, resume_pulse, restart_pc;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct { int stamp; logic rpc; } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  halt_wake_seq #(.PORT_W(PW), .DELAY_CYC(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .wdt_clr(wdt_clr),
    .wdt_wake(wdt_wake), .port_in(port_in), .wake_mask(wake_mask),
    .core_en(core_en), .wdt_pre_clr(wdt_pre_clr), .pdf_flag(pdf_flag),
    .to_flag(to_flag), .resume_pulse(resume_pulse), .restart_pc(restart_pc)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver side: record expected resume stamp and cause
  task automatic expect_resume(int lead, logic rpc);
    exp_t e;
    e.stamp = cyc + lead;
    e.rpc   = rpc;
    exp_q.push_back(e);
  endtask

  // monitor: pop and compare on every resume pulse
  always @(posedge clk) begin
    #1;
    if (resume_pulse && rst_n) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected resume", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R4 resume cycle", cyc, e.stamp);
        check("R5 restart_pc", int'(restart_pc), int'(e.rpc));
        check("R4 core_en at resume", int'(core_en), 1);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_halt(logic with_clr);
    @(negedge clk);
    halt_req = 1'b1; wdt_clr = with_clr;
    @(negedge clk);
    halt_req = 1'b0; wdt_clr = 1'b0;
  endtask

  task automatic wait_queue_empty();
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
    tick(2);
  endtask

  initial begin
    tick(3);
    // R1 during reset
    check("R1 core_en in reset", int'(core_en), 1);
    check("R1 pdf in reset", int'(pdf_flag), 0);
    @(negedge clk) rst_n = 1'b1;
    tick(1);
    check("R1 core_en", int'(core_en), 1);
    check("R1 pdf_flag", int'(pdf_flag), 0);
    check("R1 to_flag", int'(to_flag), 0);
    check("R1 resume/restart", int'({resume_pulse, restart_pc, wdt_pre_clr}), 0);

    // R9: wake sources while running
    @(negedge clk); wdt_wake = 1'b1; port_in[0] = 1'b0;
    @(negedge clk); wdt_wake = 1'b0;
    tick(6);
    check("R9 core_en running", int'(core_en), 1);
    port_in[0] = 1'b1;
    tick(5);

    // R2 + R6 tie: halt together with clear
    do_halt(1'b1);
    check("R2 core_en off", int'(core_en), 0);
    check("R6 halt wins over clr", int'(pdf_flag), 1);
    check("R2 to_flag cleared", int'(to_flag), 0);
    check("R2 pre_clr pulse", int'(wdt_pre_clr), 1);
    tick(1);
    check("R2 pre_clr single", int'(wdt_pre_clr), 0);

    // R3: masked bit does not wake
    port_in[3] = 1'b0;
    tick(10);
    check("R3 masked bit ignored", int'(core_en), 0);
    port_in[3] = 1'b1;
    tick(10);
    check("R3 rising edge ignored", int'(core_en), 0);

    // R3/R4: enabled bit falls
    port_in[0] = 1'b0;
    expect_resume(DLY + 3, 1'b0);
    tick(200);
    check("R4 stalled during settle", int'(core_en), 0);
    // R7: halt strobe while settling
    halt_req = 1'b1; @(negedge clk); halt_req = 1'b0;
    wait_queue_empty();
    check("R4 running after resume", int'(core_en), 1);
    check("R5 port wake keeps to_flag", int'(to_flag), 0);
    check("R6 pdf still set", int'(pdf_flag), 1);
    wdt_clr = 1'b1; @(negedge clk); wdt_clr = 1'b0;
    check("R6 pdf cleared by clr", int'(pdf_flag), 0);
    port_in[0] = 1'b1;
    tick(5);

    // R5: watchdog wake
    do_halt(1'b0);
    halt_req = 1'b1; @(negedge clk); halt_req = 1'b0;   // R7 while halted
    check("R7 halt ignored in halt", int'(wdt_pre_clr), 0);
    wdt_wake = 1'b1;
    expect_resume(DLY + 1, 1'b1);
    @(negedge clk); wdt_wake = 1'b0;
    check("R5 to_flag set", int'(to_flag), 1);
    wait_queue_empty();

    // R5 tie: port edge and watchdog at the same detecting edge
    do_halt(1'b0);
    port_in[0] = 1'b0;
    expect_resume(DLY + 3, 1'b1);
    tick(2);
    wdt_wake = 1'b1; @(negedge clk); wdt_wake = 1'b0;
    wait_queue_empty();
    port_in[0] = 1'b1;
    tick(5);

    // R8: reset during settle
    do_halt(1'b0);
    wdt_wake = 1'b1; @(negedge clk); wdt_wake = 1'b0;
    tick(50);
    rst_n = 1'b0;
    #2;
    check("R8 core_en on reset", int'(core_en), 1);
    check("R8 pdf on reset", int'(pdf_flag), 0);
    check("R8 to on reset", int'(to_flag), 0);
    exp_q.delete();
    tick(2);
    rst_n = 1'b1;
    tick(1100);
    check("R8 no resume after reset", exp_q.size(), 0);
    check("R8 still running", int'(core_en), 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, LIMIT);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule